// File: doc/BRIEF.md
# Three-Backplane Multiplexed LCD Drive Timing Generator

This block produces the frame timing and per-line drive levels for a liquid crystal display that shares three backplanes among all of its segments. From a free-running oscillator clock it derives a frame of 1200 cycles. The frame is cut into three equal backplane slots, and each slot is cut into two halves of opposite polarity, so every line carries zero net DC over a slot. Every output line gets a two-bit level code (low, mid or high). An external analog level shifter turns these codes into voltages.

A 36-bit display word serves twelve segment lines. Each line carries three segments of one digit, one per backplane slot. The slots hold the groups (A,G,D), (B,C,extra) and (F,E,decimal point). On some lines the extra slot carries an indicator such as continuity, low battery, minus sign or the half digit. The display word is a plain level input, not a stream. There is no valid/ready handshake and no back-pressure. The block samples the word only at the last cycle of a frame, so the producer only has to hold it stable across that cycle. A one-bit annunciator output is a square wave at the frame rate. A display element wired to it shows as on, and one wired to its own backplane shows as off.

Top module: `lcd3_drive_gen`

## Requirements
- R1: The frame is 1200 clock cycles long. It is made of slots 0, 1 and 2 in that order, each 400 cycles long. Each slot is split into a first half and a second half of 200 cycles each. After reset the frame starts again from slot 0, first half.
- R2: Level codes are 2'b00 = low, 2'b01 = mid and 2'b10 = high. Backplane k drives bp_lvl[2k+1:2k]. It is high in the first half of slot k and low in the second half of slot k, and mid in every other slot. This holds whatever the display word is.
- R3: Bit seg_bits[3*n+s] controls line n during slot s. When the sampled bit is 1, seg_lvl[2n+1:2n] is low in the first half of slot s and high in the second half, which is the opposite of the active backplane.
- R4: When the sampled bit is 0, line n is mid for the whole of slot s.
- R5: seg_bits is sampled only at the clock edge that ends a frame, and that sample drives the whole of the next frame. A change to seg_bits at any other time has no effect on seg_lvl.
- R6: ann_out is 1 for the first 600 cycles of every frame and 0 for the last 600 cycles.
- R7: While reset is held and right after it, the timing sits at slot 0, first half, and the sampled display word is all zeros. Every segment line is therefore mid for the whole first frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_bits | input | 36 | Display word, bit 3*n+s for line n, slot s |
| bp_lvl | output | 6 | Level codes of the three backplanes, 2 bits each |
| seg_lvl | output | 24 | Level codes of the twelve segment lines, 2 bits each |
| ann_out | output | 1 | Frame-rate square wave for the annunciator |

## Verification
A wrong cycle counter shows up on the backplane codes within one slot. A slot change then lands at the wrong cycle, and the annunciator edge moves away from cycle 600. A fault in the display-word register shows up as soon as the first slot of the next frame: a bit that was loaded mid-frame or lost alters a segment code. The bench compares every output on every cycle against a model driven only by cycle position and the words sampled at frame ends. It also toggles junk onto seg_bits between frame ends to catch sampling at the wrong time.

// File: rtl/lcd3_pkg.sv
package lcd3_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;
endpackage

// File: rtl/lcd3_frame_timer.sv
module lcd3_frame_timer #(
  parameter int HALF_CYCLES = 200,
  parameter int NUM_SLOTS   = 3,
  localparam int CNT_W  = $clog2(HALF_CYCLES),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic              phase,
  output logic              frame_end,
  output logic              ann
);
  localparam logic [CNT_W-1:0]  HALF_LAST = CNT_W'(HALF_CYCLES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [CNT_W-1:0] half_cnt;
  logic             half_end;

  assign half_end  = (half_cnt == HALF_LAST);
  assign frame_end = half_end && phase && (slot == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_cnt <= '0;
      phase    <= 1'b0;
      slot     <= '0;
    end else if (half_end) begin
      half_cnt <= '0;
      phase    <= ~phase;
      if (phase) slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  // Annunciator: high over the first NUM_SLOTS half-slots of the frame.
  always_comb begin
    int halves_done;
    halves_done = 2 * int'(slot) + int'(phase);
    ann = (halves_done < NUM_SLOTS);
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    half_cnt <= HALF_LAST && slot <= SLOT_LAST);

  assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != $past(slot)) |-> ($past(half_end) && $past(phase)));

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> $past(half_end));
endmodule

// File: rtl/lcd3_backplane_drv.sv
module lcd3_backplane_drv
  import lcd3_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOT_W-1:0]      slot,
  input  logic                   phase,
  output logic [2*NUM_SLOTS-1:0] bp_lvl
);
  logic [NUM_SLOTS-1:0] bp_active;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_bp
    assign bp_active[k] = (slot == SLOT_W'(k));
    assign bp_lvl[2*k +: 2] = bp_active[k] ? (phase ? LVL_LOW : LVL_HIGH) : LVL_MID;
  end

  // R2: exactly one backplane leaves the mid level at any time
  assert_one_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bp_active) == 1);
endmodule

// File: rtl/lcd3_segment_drv.sv
module lcd3_segment_drv
  import lcd3_pkg::*;
#(
  parameter int NUM_LINES = 12,
  parameter int NUM_SLOTS = 3,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int BITS   = NUM_LINES * NUM_SLOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOT_W-1:0]      slot,
  input  logic                   phase,
  input  logic                   frame_end,
  input  logic [BITS-1:0]        seg_bits,
  output logic [2*NUM_LINES-1:0] seg_lvl
);
  logic [BITS-1:0] seg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         seg_q <= '0;
    else if (frame_end) seg_q <= seg_bits;
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [NUM_SLOTS-1:0] grp;
    logic                 on;
    assign grp = seg_q[n*NUM_SLOTS +: NUM_SLOTS];
    assign on  = grp[slot];
    assign seg_lvl[2*n +: 2] = on ? (phase ? LVL_HIGH : LVL_LOW) : LVL_MID;
  end

  assert_frame_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> $stable(seg_q));

  assert_no_high_first_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |-> !(|(seg_lvl & {NUM_LINES{2'b10}})));
endmodule

// File: rtl/lcd3_drive_gen.sv
module lcd3_drive_gen #(
  parameter int HALF_CYCLES = 200,
  parameter int NUM_SLOTS   = 3,
  parameter int NUM_LINES   = 12,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int BITS   = NUM_LINES * NUM_SLOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BITS-1:0]        seg_bits,
  output logic [2*NUM_SLOTS-1:0] bp_lvl,
  output logic [2*NUM_LINES-1:0] seg_lvl,
  output logic                   ann_out
);
  logic [SLOT_W-1:0] slot;
  logic              phase;
  logic              frame_end;

  lcd3_frame_timer #(.HALF_CYCLES(HALF_CYCLES), .NUM_SLOTS(NUM_SLOTS)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot(slot), .phase(phase),
    .frame_end(frame_end), .ann(ann_out)
  );

  lcd3_backplane_drv #(.NUM_SLOTS(NUM_SLOTS)) u_bp (
    .clk(clk), .rst_n(rst_n), .slot(slot), .phase(phase), .bp_lvl(bp_lvl)
  );

  lcd3_segment_drv #(.NUM_LINES(NUM_LINES), .NUM_SLOTS(NUM_SLOTS)) u_seg (
    .clk(clk), .rst_n(rst_n), .slot(slot), .phase(phase),
    .frame_end(frame_end), .seg_bits(seg_bits), .seg_lvl(seg_lvl)
  );

  // R6: annunciator rises only when a new frame begins
  assert_ann_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ann_out) |-> (slot == '0 && !phase && $past(frame_end)));

  assert_ann_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ann_out) |-> (phase != $past(phase)));
endmodule

// File: tb/tb_lcd3_drive_gen.sv
module tb_lcd3_drive_gen;
  localparam int FRAME = 1200;
  localparam int SLOTC = 400;
  localparam int HALFC = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] seg_bits = '0;
  logic [5:0]  bp_lvl;
  logic [23:0] seg_lvl;
  logic        ann_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  lcd3_drive_gen dut (
    .clk(clk), .rst_n(rst_n), .seg_bits(seg_bits),
    .bp_lvl(bp_lvl), .seg_lvl(seg_lvl), .ann_out(ann_out)
  );

  function automatic logic [5:0] exp_bp(int pos);
    logic [5:0] r;
    for (int k = 0; k < 3; k++) begin
      if (pos / SLOTC == k) r[2*k +: 2] = ((pos % SLOTC) < HALFC) ? 2'b10 : 2'b00;
      else                  r[2*k +: 2] = 2'b01;
    end
    return r;
  endfunction

  function automatic logic [23:0] exp_seg(int pos, logic [35:0] d);
    logic [23:0] r;
    int s;
    s = pos / SLOTC;
    for (int n = 0; n < 12; n++) begin
      if (d[3*n + s]) r[2*n +: 2] = ((pos % SLOTC) < HALFC) ? 2'b00 : 2'b10;
      else            r[2*n +: 2] = 2'b01;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, int cyc);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [35:0] rnd36();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[35:0];
  endfunction

  function automatic logic [35:0] pattern(int f);
    case (f)
      1: return '1;
      2: return '0;
      3: return 36'h555555555;
      4: return 36'haaaaaaaaa;
      5: return 36'h249249249;
      default: return rnd36();
    endcase
  endfunction

  initial begin
    logic [35:0] cur;
    void'($urandom(32'd1234));
    cur = '0;
    seg_bits = rnd36();
    repeat (3) @(negedge clk);
    // R7: reset state while reset is held
    chk("R7 reset bp", 32'(bp_lvl), 32'(6'b01_01_10), -1);
    chk("R7 reset seg", 32'(seg_lvl), 32'({12{2'b01}}), -1);
    chk("R7 reset ann", 32'(ann_out), 32'd1, -1);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 9 * FRAME; cyc++) begin
      int pos;
      int f;
      pos = cyc % FRAME;
      f   = cyc / FRAME;
      chk("R1 R2 backplane", 32'(bp_lvl), 32'(exp_bp(pos)), cyc);
      chk((f == 0) ? "R7 first frame off" : "R3 R4 R5 segment",
          32'(seg_lvl), 32'(exp_seg(pos, cur)), cyc);
      chk("R6 annunciator", 32'(ann_out), 32'(pos < FRAME / 2), cyc);
      if (pos == FRAME - 1) cur = seg_bits;
      else if (pos == 1100) seg_bits = pattern(f + 1);
      else if (pos < 1100 && (pos % 37) == 5) seg_bits = rnd36(); // R5 junk mid-frame
      @(negedge clk);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule